// File: doc/BRIEF.md
# Programmed I/O Pulse Timing Adapter

This block sits between a fast 18-bit host and a slower 12-bit peripheral and reshapes the host's programmed I/O timing into what the peripheral can follow. When the host loads an I/O instruction, the adapter captures the device-select field and the accumulator-clear microbit. It then replays the host's raw I/O pulses to the peripheral in a fixed order (first, second, fourth). The first replayed pulse is held back long enough for the unbuffered accumulator and memory-buffer buses to settle. Later pulses are spread to a minimum spacing.

While a sequence runs, the adapter asks the host for a slow I/O cycle. This gives the peripheral's skip answer, which is sampled at the end of the second pulse, time to reach the host before the program counter moves on. A build parameter can instead pass through a slow-cycle request raised by the peripheral itself.

Data paths are narrowed or widened between the two word sizes. Only the low twelve accumulator bits go out, and returned data lands only in the low twelve bits. The host's start and clear-all-flags events become a power-clear pulse, and two host timing pulses are re-timed as memory-timing pulses. All delays are whole clock cycles set by parameters.

Top module: `pio_pulse_adapter`

## Requirements
- R1: `busAcc` always equals `hostAcc[11:0]`; the upper six accumulator bits never reach the peripheral.
- R2: `hostAccRet[17:12]` equals `hostAcc[17:12]`. `hostAccRet[11:0]` equals `perAccIn` OR'd with `hostAcc[11:0]`, or with zero when the captured clear microbit (instruction bit 12) is 1.
- R3: On the clock edge that accepts an instruction, `devSel` takes `instrWord[11:6]` and the clear microbit takes `instrWord[12]`. Instruction bits 5..0 and 17..13 have no effect on any output.
- R4: The first replayed pulse after an accepted instruction rises SETTLE_CYC clock edges after the accepting edge. If its raw pulse is sampled at edge d after acceptance and d+1 exceeds SETTLE_CYC, it rises at edge d+1 instead.
- R5: Output pulses appear on `iopOut` bits 0, 1, 2 (first, second, fourth pulse), never two at once. A pending lower bit is always served before a higher one. Each pulse lasts PULSE_W cycles, and consecutive pulses rise GAP_CYC edges apart.
- R6: An instruction load that arrives while a pulse is active, or fewer than GAP_CYC edges after the last pulse rose, is held. It is accepted on the first edge where neither holds.
- R7: `hostSkip` takes the value of `perSkip` in the last cycle of the replayed second pulse, clears to 0 when an instruction is accepted, and holds otherwise. `hostIrq` follows `perIrq`.
- R8: With FORCE_SLOW=1, `hostSlowReq` rises on the accepting edge and falls on the edge that ends the replayed fourth pulse.
- R9: With FORCE_SLOW=0, `hostSlowReq` follows `perSlowReq` directly.
- R10: `pwrClr` is high for the cycle after each edge at which `hostBegin` or `hostClrFlags` is sampled high.
- R11: `bt1` and `bt2` are one-cycle registered copies of `hostTp6` and `hostTp4`.
- R12: Synchronous active-high `rst` clears pending pulses, the held load, the captured fields, `hostSkip`, `hostSlowReq` (forced mode), `pwrClr`, `bt1` and `bt2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| irLoad | input | 1 | Strobe: an I/O instruction was loaded |
| instrWord | input | 18 | Loaded instruction word |
| rawIop | input | 3 | Raw host I/O pulses (first, second, fourth) |
| hostTp6 | input | 1 | Host timing pulse for core write |
| hostTp4 | input | 1 | Host timing pulse for core read |
| hostBegin | input | 1 | Start-key begin event |
| hostClrFlags | input | 1 | Clear-all-flags / power-on event |
| hostAcc | input | 18 | Host accumulator output |
| perAccIn | input | 12 | Peripheral accumulator return data |
| perSkip | input | 1 | Peripheral skip answer |
| perIrq | input | 1 | Peripheral interrupt request |
| perSlowReq | input | 1 | Peripheral slow-cycle request |
| iopOut | output | 3 | Delayed, spaced I/O pulses to peripheral |
| hostSlowReq | output | 1 | Slow-cycle request to host |
| busAcc | output | 12 | Buffered accumulator bus to peripheral |
| hostAccRet | output | 18 | Accumulator load value to host |
| devSel | output | 6 | Captured device-select field |
| hostSkip | output | 1 | Skip answer to host |
| hostIrq | output | 1 | Interrupt request to host |
| pwrClr | output | 1 | Power-clear pulse |
| bt1 | output | 1 | Memory-timing pulse from TP6 |
| bt2 | output | 1 | Memory-timing pulse from TP4 |

## Verification
The bench builds the adapter with SETTLE_CYC=3, GAP_CYC=5 and PULSE_W=2. It uses two instances: one with FORCE_SLOW=1 and one with FORCE_SLOW=0. The short windows let every non-empty pulse mask be swept against every raw-pulse arrival offset from 0 to 6. That covers both the case where the settle delay dominates and the case where late arrival does, and the full pulse waveform is compared each cycle. The 6-bit device field is small enough to sweep all 64 values with both clear-microbit settings.

// File: rtl/pio_adapt_pkg.sv
package pio_adapt_pkg;
  parameter int HOST_W  = 18;
  parameter int PER_W   = 12;
  parameter int DEV_LSB = 6;
  parameter int DEV_W   = 6;
  parameter int CLR_BIT = 12;
  parameter int NUM_IOP = 3;
  localparam int CAP_W  = CLR_BIT - DEV_LSB + 1;

  typedef struct packed {
    logic accept;   // instruction accepted this cycle
    logic skipCap;  // last beat of replayed second pulse
  } pioStrb_t;
endpackage

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_adapt_pkg::*;
#(
  parameter int SETTLE_CYC = 12,
  parameter int GAP_CYC    = 100,
  parameter int PULSE_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irLoad,
  input  logic [NUM_IOP-1:0] rawIop,
  output pioStrb_t           strb,
  output logic [NUM_IOP-1:0] iopOut,
  output logic               seqOn
);
  localparam int LIM_MAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam int W_W     = $clog2(PULSE_W + 1);
  localparam int SEL_W   = $clog2(NUM_IOP);

  logic [CNT_W-1:0]   gapCnt;
  logic [NUM_IOP-1:0] pend;
  logic               held, firstDone, act;
  logic [SEL_W-1:0]   sel;
  logic [W_W-1:0]     wCnt;

  logic               lastBeat, accept, startAny;
  logic [CNT_W-1:0]   limit;
  logic [NUM_IOP-1:0] startVec;
  logic [SEL_W-1:0]   startIdx;

  assign lastBeat = act && (wCnt == W_W'(PULSE_W - 1));
  assign limit    = firstDone ? CNT_W'(GAP_CYC - 1) : CNT_W'(SETTLE_CYC - 1);
  assign accept   = (irLoad || held) && !act && (gapCnt >= CNT_W'(GAP_CYC - 1));

  // lowest pending pulse wins the slot
  always_comb begin
    startVec = '0;
    startIdx = '0;
    if (!act && !accept && (gapCnt >= limit)) begin
      for (int i = NUM_IOP - 1; i >= 0; i--) begin
        if (pend[i]) begin
          startVec = '0;
          startVec[i] = 1'b1;
          startIdx = SEL_W'(i);
        end
      end
    end
  end
  assign startAny = |startVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt    <= '0;
      pend      <= '0;
      held      <= 1'b0;
      firstDone <= 1'b0;
      act       <= 1'b0;
      sel       <= '0;
      wCnt      <= '0;
      seqOn     <= 1'b0;
    end else begin
      pend <= (pend | rawIop) & ~startVec;
      held <= !accept && (held || irLoad);
      if (accept || startAny)  gapCnt <= '0;
      else if (gapCnt != '1)   gapCnt <= gapCnt + 1'b1;
      if (accept)              firstDone <= 1'b0;
      else if (startAny)       firstDone <= 1'b1;
      if (startAny) begin
        act  <= 1'b1;
        sel  <= startIdx;
        wCnt <= '0;
      end else if (lastBeat) begin
        act  <= 1'b0;
      end else if (act) begin
        wCnt <= wCnt + 1'b1;
      end
      if (accept)                                       seqOn <= 1'b1;
      else if (lastBeat && sel == SEL_W'(NUM_IOP - 1))  seqOn <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_IOP; g++) begin : gen_iop
    assign iopOut[g] = act && (sel == SEL_W'(g));
  end

  assign strb.accept  = accept;
  assign strb.skipCap = lastBeat && (sel == SEL_W'(1));

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(iopOut)); // R5
  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (rst)
    (act && !lastBeat) |=> (act && $stable(sel))); // R5
  AST_QUIET_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    strb.accept |=> (iopOut == '0)); // R4
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_adapt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  pioStrb_t          strb,
  input  logic [HOST_W-1:0] instrWord,
  input  logic [HOST_W-1:0] hostAcc,
  input  logic [PER_W-1:0]  perAccIn,
  input  logic              perSkip,
  input  logic              perIrq,
  input  logic              hostBegin,
  input  logic              hostClrFlags,
  input  logic              hostTp6,
  input  logic              hostTp4,
  output logic [PER_W-1:0]  busAcc,
  output logic [HOST_W-1:0] hostAccRet,
  output logic [DEV_W-1:0]  devSel,
  output logic              hostSkip,
  output logic              hostIrq,
  output logic              pwrClr,
  output logic              bt1,
  output logic              bt2
);
  logic [CAP_W-1:0] capField;
  logic             clrMicro;
  logic             unusedInstrBits;

  assign unusedInstrBits = ^{instrWord[HOST_W-1:CLR_BIT+1], instrWord[DEV_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      capField <= '0;
      hostSkip <= 1'b0;
      pwrClr   <= 1'b0;
      bt1      <= 1'b0;
      bt2      <= 1'b0;
    end else begin
      if (strb.accept) begin
        capField <= instrWord[CLR_BIT:DEV_LSB];
        hostSkip <= 1'b0;
      end else if (strb.skipCap) begin
        hostSkip <= perSkip;
      end
      pwrClr <= hostBegin | hostClrFlags;
      bt1    <= hostTp6;
      bt2    <= hostTp4;
    end
  end

  assign clrMicro   = capField[CAP_W-1];
  assign devSel     = capField[DEV_W-1:0];
  assign busAcc     = hostAcc[PER_W-1:0];
  assign hostAccRet = {hostAcc[HOST_W-1:PER_W],
                       (clrMicro ? {PER_W{1'b0}} : hostAcc[PER_W-1:0]) | perAccIn};
  assign hostIrq    = perIrq;

  AST_DEV_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strb.accept |=> $stable(devSel)); // R3
  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strb.accept && !strb.skipCap) |=> $stable(hostSkip)); // R7
endmodule

// File: rtl/pio_pulse_adapter.sv
module pio_pulse_adapter
  import pio_adapt_pkg::*;
#(
  parameter int SETTLE_CYC = 12,
  parameter int GAP_CYC    = 100,
  parameter int PULSE_W    = 4,
  parameter bit FORCE_SLOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irLoad,
  input  logic [HOST_W-1:0] instrWord,
  input  logic [NUM_IOP-1:0] rawIop,
  input  logic              hostTp6,
  input  logic              hostTp4,
  input  logic              hostBegin,
  input  logic              hostClrFlags,
  input  logic [HOST_W-1:0] hostAcc,
  input  logic [PER_W-1:0]  perAccIn,
  input  logic              perSkip,
  input  logic              perIrq,
  input  logic              perSlowReq,
  output logic [NUM_IOP-1:0] iopOut,
  output logic              hostSlowReq,
  output logic [PER_W-1:0]  busAcc,
  output logic [HOST_W-1:0] hostAccRet,
  output logic [DEV_W-1:0]  devSel,
  output logic              hostSkip,
  output logic              hostIrq,
  output logic              pwrClr,
  output logic              bt1,
  output logic              bt2
);
  pioStrb_t strb;
  logic     seqOn;

  pio_seq_ctrl #(
    .SETTLE_CYC(SETTLE_CYC),
    .GAP_CYC   (GAP_CYC),
    .PULSE_W   (PULSE_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .irLoad (irLoad),
    .rawIop (rawIop),
    .strb   (strb),
    .iopOut (iopOut),
    .seqOn  (seqOn)
  );

  pio_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .instrWord   (instrWord),
    .hostAcc     (hostAcc),
    .perAccIn    (perAccIn),
    .perSkip     (perSkip),
    .perIrq      (perIrq),
    .hostBegin   (hostBegin),
    .hostClrFlags(hostClrFlags),
    .hostTp6     (hostTp6),
    .hostTp4     (hostTp4),
    .busAcc      (busAcc),
    .hostAccRet  (hostAccRet),
    .devSel      (devSel),
    .hostSkip    (hostSkip),
    .hostIrq     (hostIrq),
    .pwrClr      (pwrClr),
    .bt1         (bt1),
    .bt2         (bt2)
  );

  if (FORCE_SLOW) begin : gen_forced
    logic unusedPerSlow;
    assign unusedPerSlow = perSlowReq;
    assign hostSlowReq   = seqOn;
  end else begin : gen_follow
    logic unusedSeqOn;
    assign unusedSeqOn = seqOn;
    assign hostSlowReq = perSlowReq;
  end
endmodule

// File: tb/test_pio_pulse_adapter.sv
module test_pio_pulse_adapter;
  localparam int SETTLE = 3;
  localparam int GAP    = 5;
  localparam int PW     = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irLoad = 1'b0;
  logic [17:0] instrWord = '0;
  logic [2:0]  rawIop = '0;
  logic        hostTp6 = 1'b0, hostTp4 = 1'b0, hostBegin = 1'b0, hostClrFlags = 1'b0;
  logic [17:0] hostAcc = '0;
  logic [11:0] perAccIn = '0;
  logic        perSkip = 1'b0, perIrq = 1'b0, perSlowReq = 1'b0;

  logic [2:0]  iopOut;
  logic        hostSlowReq, hostSkip, hostIrq, pwrClr, bt1, bt2;
  logic [11:0] busAcc;
  logic [17:0] hostAccRet;
  logic [5:0]  devSel;

  logic [2:0]  pIop;
  logic        pSlow, pSkip, pIrq, pPwr, pBt1, pBt2;
  logic [11:0] pBus;
  logic [17:0] pRet;
  logic [5:0]  pDev;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pio_pulse_adapter #(.SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .PULSE_W(PW), .FORCE_SLOW(1'b1))
    i_pio_pulse_adapter (
      .clk(clk), .rst(rst), .irLoad(irLoad), .instrWord(instrWord), .rawIop(rawIop),
      .hostTp6(hostTp6), .hostTp4(hostTp4), .hostBegin(hostBegin), .hostClrFlags(hostClrFlags),
      .hostAcc(hostAcc), .perAccIn(perAccIn), .perSkip(perSkip), .perIrq(perIrq),
      .perSlowReq(perSlowReq), .iopOut(iopOut), .hostSlowReq(hostSlowReq), .busAcc(busAcc),
      .hostAccRet(hostAccRet), .devSel(devSel), .hostSkip(hostSkip), .hostIrq(hostIrq),
      .pwrClr(pwrClr), .bt1(bt1), .bt2(bt2));

  pio_pulse_adapter #(.SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .PULSE_W(PW), .FORCE_SLOW(1'b0))
    i_pio_pulse_adapter_per (
      .clk(clk), .rst(rst), .irLoad(irLoad), .instrWord(instrWord), .rawIop(rawIop),
      .hostTp6(hostTp6), .hostTp4(hostTp4), .hostBegin(hostBegin), .hostClrFlags(hostClrFlags),
      .hostAcc(hostAcc), .perAccIn(perAccIn), .perSkip(perSkip), .perIrq(perIrq),
      .perSlowReq(perSlowReq), .iopOut(pIop), .hostSlowReq(pSlow), .busAcc(pBus),
      .hostAccRet(pRet), .devSel(pDev), .hostSkip(pSkip), .hostIrq(pIrq),
      .pwrClr(pPwr), .bt1(pBt1), .bt2(pBt2));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expIop(input int m, input int base, input int j);
    logic [2:0] e;
    int k;
    e = '0;
    k = 0;
    for (int b = 0; b < 3; b++) begin
      if (m[b]) begin
        if (j >= base + k * GAP && j < base + k * GAP + PW) e[b] = 1'b1;
        k++;
      end
    end
    return e;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadInstr(input logic [17:0] w);
    @(negedge clk);
    irLoad = 1'b1;
    instrWord = w;
    @(negedge clk);
    irLoad = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(iopOut == 3'b0, "R12", "iopOut", 32'(iopOut), 0);
    chk(hostSlowReq == 1'b0 && hostSkip == 1'b0, "R12", "slow/skip", {hostSlowReq, hostSkip}, 0);
    chk(devSel == 6'd0 && pwrClr == 1'b0 && bt1 == 1'b0 && bt2 == 1'b0, "R12", "dev/pwr/bt",
        {devSel, pwrClr, bt1, bt2}, 0);
    rst = 1'b0;
    idle(8);

    // R4 R5 R7 R8: sweep every pulse mask against raw arrival offsets
    for (int m = 1; m < 8; m++) begin
      for (int d = 0; d < 7; d++) begin
        int errs;
        int base;
        logic sk;
        errs = 0;
        base = (d + 1 > SETTLE) ? d + 1 : SETTLE;
        sk = 1'((m + d) % 2);
        perSkip = sk;
        @(negedge clk);
        irLoad = 1'b1;
        instrWord = '0;
        rawIop = (d == 0) ? 3'(m) : 3'b0;
        for (int j = 0; j < 24; j++) begin
          @(negedge clk);
          irLoad = 1'b0;
          rawIop = (d >= 1 && j == d - 1) ? 3'(m) : 3'b0;
          if (iopOut !== expIop(m, base, j)) errs++;
          if (j == 0) chk(hostSlowReq == 1'b1, "R8", "slow req at accept", 32'(hostSlowReq), 1);
        end
        chk(errs == 0, "R4 R5", $sformatf("pulse waveform m=%0d d=%0d", m, d), errs, 0);
        chk(hostSkip == (m[1] ? sk : 1'b0), "R7", $sformatf("skip m=%0d", m),
            32'(hostSkip), 32'(m[1] ? sk : 1'b0));
        chk(hostSlowReq == (m[2] ? 1'b0 : 1'b1), "R8", $sformatf("slow req end m=%0d", m),
            32'(hostSlowReq), 32'(m[2] ? 1'b0 : 1'b1));
      end
    end

    // R6: a second load during a running sequence is held
    idle(6);
    @(negedge clk);
    irLoad = 1'b1;
    instrWord = 18'(5 << 6);
    rawIop = 3'b001;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      rawIop = 3'b0;
      irLoad = (j == 0);
      if (j == 0) instrWord = 18'(9 << 6);
      if (j == 7) chk(devSel == 6'd5, "R6", "held load not yet taken", 32'(devSel), 5);
      if (j == 8) chk(devSel == 6'd9, "R6", "held load taken", 32'(devSel), 9);
    end
    idle(8);

    // R1 R2 R3: device field sweep, clear microbit, ignored bits
    for (int dv = 0; dv < 64; dv++) begin
      for (int c = 0; c < 2; c++) begin
        logic [17:0] w;
        logic [17:0] accPat;
        logic [11:0] retPat;
        logic [11:0] lowExp;
        w = {5'(dv * 7 + c), 1'(c), 6'(dv), 6'(dv ^ 6'h2a)};
        loadInstr(w);
        idle(6);
        chk(devSel == 6'(dv), "R3", "device field", 32'(devSel), 32'(dv));
        accPat = 18'(dv * 4099 + c * 77777) ^ 18'h2d5a7;
        retPat = 12'(dv * 37) ^ 12'h0c3;
        hostAcc = accPat;
        perAccIn = retPat;
        #1;
        chk(busAcc == accPat[11:0], "R1", "outbound accumulator", 32'(busAcc), 32'(accPat[11:0]));
        lowExp = (c == 1) ? retPat : (accPat[11:0] | retPat);
        chk(hostAccRet == {accPat[17:12], lowExp}, "R2", "returned accumulator",
            32'(hostAccRet), 32'({accPat[17:12], lowExp}));
      end
    end
    // R3: instructions differing only in ignored bits
    loadInstr({5'h1f, 1'b0, 6'h11, 6'h3f});
    idle(6);
    hostAcc = 18'h3f0f0;
    perAccIn = 12'h00f;
    #1;
    chk(devSel == 6'h11 && hostAccRet == 18'h3f0ff, "R3", "ignored bits set", 32'(hostAccRet), 32'h3f0ff);
    loadInstr({5'h00, 1'b0, 6'h11, 6'h00});
    idle(6);
    chk(devSel == 6'h11 && hostAccRet == 18'h3f0ff, "R3", "ignored bits clear", 32'(hostAccRet), 32'h3f0ff);

    // R7: interrupt pass-through
    perIrq = 1'b1;
    #1;
    chk(hostIrq == 1'b1, "R7", "irq high", 32'(hostIrq), 1);
    perIrq = 1'b0;
    #1;
    chk(hostIrq == 1'b0, "R7", "irq low", 32'(hostIrq), 0);

    // R9: peripheral-driven slow request
    perSlowReq = 1'b1;
    #1;
    chk(pSlow == 1'b1, "R9", "follow high", 32'(pSlow), 1);
    perSlowReq = 1'b0;
    #1;
    chk(pSlow == 1'b0, "R9", "follow low", 32'(pSlow), 0);

    // R10: power clear from either event
    @(negedge clk); hostBegin = 1'b1;
    @(negedge clk); hostBegin = 1'b0;
    chk(pwrClr == 1'b1, "R10", "begin event", 32'(pwrClr), 1);
    @(negedge clk);
    chk(pwrClr == 1'b0, "R10", "after begin", 32'(pwrClr), 0);
    hostClrFlags = 1'b1;
    @(negedge clk); hostClrFlags = 1'b0;
    chk(pwrClr == 1'b1, "R10", "clear-flags event", 32'(pwrClr), 1);
    @(negedge clk);
    chk(pwrClr == 1'b0, "R10", "after clear-flags", 32'(pwrClr), 0);

    // R11: memory-timing pulses
    for (int p = 0; p < 4; p++) begin
      hostTp6 = p[0];
      hostTp4 = p[1];
      @(negedge clk);
      chk(bt1 == p[0] && bt2 == p[1], "R11", $sformatf("timing p=%0d", p), {bt1, bt2}, {p[0], p[1]});
    end
    hostTp6 = 1'b0;
    hostTp4 = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule